// File: doc/BRIEF.md
# Page-Mode DRAM Device Emulator

This block stands in for the memory side of a fast page mode dynamic RAM inside a clocked design or testbench. It samples the active-low row strobe, column strobe, write strobe and output enable together with a multiplexed address once per clock. It works out what kind of cycle the controller is running from the order in which those strobes change, not from any command code, and then carries out the cycle against a small internal array.

A row strobe falling with the column strobe high opens a row. Every later column strobe fall in that row selects a column and either reads the cell or writes it. A write counts as early when the write strobe is already low at that column strobe fall, and as read-modify-write when the write strobe falls later. A row strobe falling while the column strobe is already low is a refresh that takes its row from an internal counter. A row strobe pulse with no column strobe at all is a refresh of the row on the address pins. Refreshes are reported on a one-cycle pulse with the refreshed row. A sticky flag records a write request seen at a counter-driven refresh.

Top module: `fpm_dram_emu`

## Requirements
- R1: After synchronous reset, `dout_en`, `rfsh_vld` and `proto_err` are 0, and the first counter-driven refresh reports row 0.
- R2: In an open row, a column strobe fall with `we_n` high reads the cell at word address {row, column}. The row is `addr[ROW_W-1:0]` at the row strobe fall and the column is `addr[COL_W-1:0]` at the column strobe fall. `dout` carries that word from the sample after the fall.
- R3: `dout_en` is 1 in a sample only if, at the previous sample, `ras_n`, `cas_n` and `oe_n` were all low in a read access. It returns to 0 one sample after `cas_n` or `oe_n` goes high.
- R4: `we_n` low at a column strobe fall writes `din` to {row, column}. `dout_en` stays 0 for that whole column strobe, even with `oe_n` low.
- R5: `we_n` falling while `cas_n` is low after a read column strobe writes `din` to the latched row and column. `dout` keeps the old word until the next column strobe fall.
- R6: While `ras_n` stays low, each new column strobe fall selects a new column in the same row.
- R7: A row strobe pulse with no column strobe fall gives `rfsh_vld`=1 for one sample after `ras_n` rises, with `rfsh_row` equal to the latched row. The array is left unchanged and `dout_en` stays 0.
- R8: `ras_n` falling while `cas_n` is low gives `rfsh_vld`=1 in the next sample, with `rfsh_row` equal to the refresh counter. The counter then increments. No array access takes place.
- R9: The refresh counter wraps modulo 2^REF_W (512 by default).
- R10: `we_n` low at a row strobe fall that has `cas_n` low sets `proto_err`. The flag stays 1 until reset, and the refresh is still carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data is being driven |
| rfsh_vld | output | 1 | One-cycle refresh report |
| rfsh_row | output | REF_W | Row refreshed |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The hardest state to reach from the ports is the wrap of the refresh counter. It only moves on counter-driven refreshes, so the bench runs 512 back-to-back column-before-row cycles and then checks that the next report is row 0. Read-modify-write is also awkward: the old word must stay on `dout` after the write strobe has already stored new data. The bench reaches this by raising `oe_n`, dropping `we_n` inside the same column strobe, and then re-reading the cell in a later page access.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        SESS_IDLE,
        SESS_ACCESS,
        SESS_CBR
    } sess_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic we_fall;
    } strobe_edges_t;

    function automatic logic [1:0] pick_session(input logic ras_fall, input logic ras_rise,
                                                input logic cas_low, input logic [1:0] cur);
        if (ras_fall)
            return cas_low ? SESS_CBR : SESS_ACCESS;
        else if (ras_rise)
            return SESS_IDLE;
        else
            return cur;
    endfunction

endpackage

// File: rtl/fpm_strobe_edges.sv
module fpm_strobe_edges
    import fpm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    output strobe_edges_t edges
);
    logic ras_q, cas_q, we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        edges.ras_fall = ras_q & ~ras_n;
        edges.ras_rise = ~ras_q & ras_n;
        edges.cas_fall = cas_q & ~cas_n;
        edges.we_fall  = we_q & ~we_n;
    end
endmodule

// File: rtl/fpm_cell_array.sv
module fpm_cell_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= cells[rd_addr];
    end
endmodule

// File: rtl/fpm_cycle_ctl.sv
module fpm_cycle_ctl
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int ADDR_W = 3,
    parameter int REF_W  = 9,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_edges_t     edges,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              dout_en,
    output logic              rfsh_vld,
    output logic [REF_W-1:0]  rfsh_row,
    output logic              proto_err
);
    sess_e             sess_q, sess_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              col_seen_q, col_seen_d;
    logic              ew_q, ew_d;
    logic [REF_W-1:0]  ref_ctr_q;
    logic              in_access, col_strobe;

    always_comb begin
        in_access  = (sess_q == SESS_ACCESS);
        col_strobe = in_access && edges.cas_fall;
        sess_d     = sess_e'(pick_session(edges.ras_fall, edges.ras_rise, ~cas_n, sess_q));

        col_seen_d = edges.ras_fall ? 1'b0 : (col_strobe ? 1'b1 : col_seen_q);
        ew_d       = col_strobe ? ~we_n : ew_q;

        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_addr = {row_q, col_q};
        rd_addr = {row_q, addr[COL_W-1:0]};
        if (col_strobe) begin
            if (!we_n) begin
                wr_en   = 1'b1;
                wr_addr = {row_q, addr[COL_W-1:0]};
            end else begin
                rd_en = 1'b1;
            end
        end else if (in_access && !cas_n && edges.we_fall && col_seen_q && !ew_q) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sess_q     <= SESS_IDLE;
            row_q      <= '0;
            col_q      <= '0;
            col_seen_q <= 1'b0;
            ew_q       <= 1'b0;
            ref_ctr_q  <= '0;
            dout_en    <= 1'b0;
            rfsh_vld   <= 1'b0;
            rfsh_row   <= '0;
            proto_err  <= 1'b0;
        end else begin
            sess_q     <= sess_d;
            col_seen_q <= col_seen_d;
            ew_q       <= ew_d;
            rfsh_vld   <= 1'b0;
            dout_en    <= (sess_d == SESS_ACCESS) && col_seen_d && !ew_d && !cas_n && !oe_n;
            if (edges.ras_fall && cas_n)
                row_q <= addr[ROW_W-1:0];
            if (col_strobe)
                col_q <= addr[COL_W-1:0];
            if (edges.ras_fall && !cas_n) begin
                rfsh_vld  <= 1'b1;
                rfsh_row  <= ref_ctr_q;
                ref_ctr_q <= ref_ctr_q + REF_W'(1);
                if (!we_n)
                    proto_err <= 1'b1;
            end else if (edges.ras_rise && in_access && !col_seen_q) begin
                rfsh_vld <= 1'b1;
                rfsh_row <= REF_W'(row_q);
            end
        end
    end
endmodule

// File: rtl/fpm_dram_emu.sv
module fpm_dram_emu
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int REF_W  = 9,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rfsh_vld,
    output logic [REF_W-1:0]  rfsh_row,
    output logic              proto_err
);
    localparam int AW = ROW_W + COL_W;

    strobe_edges_t edges;
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;

    fpm_strobe_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .edges (edges)
    );

    fpm_cycle_ctl #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .REF_W  (REF_W),
        .AW     (AW)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .edges     (edges),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .dout_en   (dout_en),
        .rfsh_vld  (rfsh_vld),
        .rfsh_row  (rfsh_row),
        .proto_err (proto_err)
    );

    fpm_cell_array #(
        .AW (AW),
        .DW (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (dout)
    );
endmodule

// File: rtl/fpm_dram_emu_chk.sv
module fpm_dram_emu_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dout_en,
    input logic rfsh_vld,
    input logic proto_err
);
    assert_en_needs_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> ($past(!oe_n) && $past(!cas_n)));

    assert_en_needs_row_R2: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!ras_n));

    assert_early_write_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(!ras_n) && $past(cas_n) && !cas_n && !we_n) |=> !dout_en);

    assert_refresh_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
        rfsh_vld |-> !dout_en);

    assert_cbr_reports_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n) |=> rfsh_vld);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
endmodule

bind fpm_dram_emu fpm_dram_emu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .rfsh_vld  (rfsh_vld),
    .proto_err (proto_err)
);

// File: tb/tb_fpm_dram_emu.sv
module tb_fpm_dram_emu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en, rfsh_vld, proto_err;
    logic [8:0] rfsh_row;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_emu dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .rfsh_vld(rfsh_vld),
        .rfsh_row(rfsh_row), .proto_err(proto_err)
    );

    // Fields: req[28:25] strobes{ras,cas,we,oe}[24:21] addr[20:18] din[17:10]
    //         exp_en[9] exp_dout[8:1] check_dout[0]
    localparam logic [28:0] VEC [0:NVEC-1] = '{
        {4'd1, 4'b1111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R1 idle
        {4'd6, 4'b0111, 3'd2, 8'h00, 1'b0, 8'h00, 1'b0}, // R6 open row 2
        {4'd4, 4'b0000, 3'd5, 8'hA5, 1'b0, 8'h00, 1'b0}, // R4 early write col 5, OE low
        {4'd4, 4'b0110, 3'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 CAS high
        {4'd4, 4'b0001, 3'd6, 8'h3C, 1'b0, 8'h00, 1'b0}, // R4 early write col 6
        {4'd6, 4'b0111, 3'd6, 8'h00, 1'b0, 8'h00, 1'b0}, // R6 CAS high
        {4'd2, 4'b0010, 3'd5, 8'h00, 1'b1, 8'hA5, 1'b1}, // R2 read col 5
        {4'd3, 4'b0110, 3'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // R3 CAS high turns off
        {4'd6, 4'b0010, 3'd6, 8'h00, 1'b1, 8'h3C, 1'b1}, // R6 read col 6 same row
        {4'd3, 4'b0011, 3'd6, 8'h00, 1'b0, 8'h00, 1'b0}, // R3 OE high turns off
        {4'd3, 4'b0010, 3'd6, 8'h00, 1'b1, 8'h3C, 1'b1}, // R3 OE low again
        {4'd5, 4'b0011, 3'd6, 8'h00, 1'b0, 8'h3C, 1'b1}, // R5 OE high before write
        {4'd5, 4'b0001, 3'd0, 8'h99, 1'b0, 8'h3C, 1'b1}, // R5 WE falls, old data kept
        {4'd5, 4'b0111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R5 CAS high
        {4'd5, 4'b0010, 3'd6, 8'h00, 1'b1, 8'h99, 1'b1}, // R5 new data read back
        {4'd2, 4'b1111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 close row
        {4'd2, 4'b0111, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 open row 1
        {4'd4, 4'b0000, 3'd5, 8'h11, 1'b0, 8'h00, 1'b0}, // R4 write row1 col5
        {4'd4, 4'b0111, 3'd5, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 CAS high
        {4'd2, 4'b1111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 close
        {4'd2, 4'b0111, 3'd2, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 reopen row 2
        {4'd2, 4'b0010, 3'd5, 8'h00, 1'b1, 8'hA5, 1'b1}, // R2 row 2 col 5 intact
        {4'd2, 4'b1111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 close
        {4'd2, 4'b0111, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0}, // R2 open row 1
        {4'd2, 4'b0010, 3'd5, 8'h00, 1'b1, 8'h11, 1'b1}, // R2 row 1 col 5
        {4'd2, 4'b1111, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0}  // R2 close
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] s, input logic [2:0] a, input logic [7:0] d);
        {ras_n, cas_n, we_n, oe_n} = s;
        addr = a;
        din  = d;
    endtask

    task automatic cbr(input logic we, input logic [8:0] exp_row, input bit do_check);
        drive({3'b101, 1'b1}, 3'd0, 8'h00);
        tick();
        drive({2'b00, we, 1'b1}, 3'd0, 8'h00);
        tick();
        if (do_check) begin
            check("R8 rfsh_vld", rfsh_vld, 1);
            check("R8 rfsh_row", rfsh_row, exp_row);
            check("R8 dout_en", dout_en, 0);
        end
        drive(4'b1011, 3'd0, 8'h00);
        tick();
        drive(4'b1111, 3'd0, 8'h00);
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;
        check("R1 dout_en", dout_en, 0);
        check("R1 rfsh_vld", rfsh_vld, 0);
        check("R1 proto_err", proto_err, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [28:0] v;
            v = VEC[i];
            drive(v[24:21], v[20:18], v[17:10]);
            tick();
            check($sformatf("R%0d dout_en vec %0d", v[28:25], i), dout_en, v[9]);
            if (v[0])
                check($sformatf("R%0d dout vec %0d", v[28:25], i), dout, v[8:1]);
        end

        // R7: RAS-only refresh of row 2
        drive(4'b0111, 3'd2, 8'h00); tick();
        check("R7 no drive", dout_en, 0);
        drive(4'b1111, 3'd0, 8'h00); tick();
        check("R7 rfsh_vld", rfsh_vld, 1);
        check("R7 rfsh_row", rfsh_row, 2);
        tick();
        check("R7 pulse ends", rfsh_vld, 0);
        drive(4'b0111, 3'd2, 8'h00); tick();
        drive(4'b0010, 3'd5, 8'h00); tick();
        check("R7 array unchanged", dout, 8'hA5);
        drive(4'b1111, 3'd0, 8'h00); tick();

        // R8 / R1: first counter refresh reports row 0, then row 1
        cbr(1'b1, 9'd0, 1'b1);
        cbr(1'b1, 9'd1, 1'b1);
        check("R10 no error yet", proto_err, 0);

        // R9: run the counter through a full wrap
        for (int k = 2; k < 512; k++)
            cbr(1'b1, 9'd0, 1'b0);
        cbr(1'b1, 9'd0, 1'b1);
        check("R9 wrapped", rfsh_row, 0);

        // R10: write request during counter refresh
        cbr(1'b0, 9'd1, 1'b1);
        check("R10 set", proto_err, 1);
        drive(4'b0111, 3'd1, 8'h00); tick();
        drive(4'b0010, 3'd5, 8'h00); tick();
        check("R10 refresh kept array", dout, 8'h11);
        drive(4'b1111, 3'd0, 8'h00); tick(); tick();
        check("R10 sticky", proto_err, 1);

        // R1: reset clears flag and counter
        rst = 1'b1; tick(); tick();
        rst = 1'b0;
        check("R1 flag cleared", proto_err, 0);
        cbr(1'b1, 9'd0, 1'b1);

        finish_run();
    end
endmodule